// File: doc/BRIEF.md
# Interconnect Target Error Log

This block sits beside one target port of an on-chip interconnect. When a transaction to that target fails, an error event arrives on the event input. The event carries an error kind, the requester's master identifier, the opcode, three request qualifiers and the faulting address. The unit latches these attributes into registers that software can read. It raises `err_flag` toward an interrupt aggregator and holds everything until software clears the log.

There are two independent capture sets. Standard interconnect errors fill the standard set. Such errors are an unsupported command to an idle target, a disconnected socket, or an access to an address hole that was routed to a default target. Errors that the target itself signals through its response fill the custom set. The kind field picks the set. Only the first error is kept. Later errors are dropped until software writes the main register with the clear bit set.

Top module: `tgt_errlog`

## Requirements
- R1: After reset `err_flag` is 0 and every register at word addresses 0 to 7 reads 0.
- R2: An event with `err_kind` = 2'b01 (standard) taken while no log is held does three things. It sets main register (word 0) bits [1:0] to 01. It raises `err_flag` on the next clock edge. It fills the standard set: word 1 = faulting address, word 2 = master address, word 3 = opcode, word 4 = qualifiers.
- R3: An event with `err_kind` = 2'b10 (custom) taken while no log is held does three things. It sets main bits [1:0] to 10. It fills the custom set: word 5 = master address, word 6 = opcode, word 7 = qualifiers. It leaves words 1 to 4 unchanged.
- R4: An event with `err_kind` of 2'b00 or 2'b11 logs nothing: `err_flag` stays 0 and every word keeps its value.
- R5: In words 2 and 5 the master identifier sits in bits [MID_LSB+MID_W-1:MID_LSB], and all other bits read 0.
- R6: Words 3 and 6 hold the opcode in bits [2:0], and all other bits read 0.
- R7: Words 4 and 7 hold the qualifiers as follows: bit 0 = instruction fetch (0 = data access), bit 1 = supervisor (0 = user), bit 3 = debug (0 = functional). Bit 2 and bits [31:4] read 0.
- R8: While a log is held, any new event leaves every word unchanged.
- R9: A write to word 0 with bit CLR_BIT (default 8) set clears main bits [1:0] and drops `err_flag` on the next edge. The data words keep their values. A write to word 0 without that bit, or a write to any other word, has no effect.
- R10: If a clear write and a valid-kind event occur in the same cycle, the new event is captured and `err_flag` stays 1.
- R11: `err_flag` is 1 exactly when main bits [1:0] are nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| err_valid | input | 1 | Error event strobe, one cycle per event |
| err_kind | input | 2 | 01 standard, 10 custom, else ignored |
| err_mid | input | MID_W | Requesting master identifier |
| err_opc | input | 3 | Transaction opcode |
| err_fetch | input | 1 | Request was an instruction fetch |
| err_sup | input | 1 | Request was in supervisor mode |
| err_dbg | input | 1 | Request was a debug access |
| err_addr | input | ADDR_W | Faulting slave address offset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| err_flag | output | 1 | Log-held flag toward the interrupt aggregator |

## Verification
The assertions assume that `err_kind` is meaningful only while `err_valid` is high. They also assume that a write clears the log only when it targets word 0 with the clear bit set. The bench holds each event strobe for exactly one cycle and always returns `reg_we` low between writes. It drives event and write inputs only on falling edges, so that every rising edge sees one settled request. Reads take place only after a capture or clear edge has passed, which keeps every expected value tied to a single earlier edge.

// File: rtl/tgt_errlog.sv
module tgt_errlog #(
  parameter int ADDR_W  = 32,
  parameter int MID_W   = 6,
  parameter int MID_LSB = 8,
  parameter int CLR_BIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_valid,
  input  logic [1:0]        err_kind,
  input  logic [MID_W-1:0]  err_mid,
  input  logic [2:0]        err_opc,
  input  logic              err_fetch,
  input  logic              err_sup,
  input  logic              err_dbg,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              err_flag
);
  localparam int DW = 32;
  localparam logic [1:0] K_STD  = 2'b01;
  localparam logic [1:0] K_CUST = 2'b10;

  logic [1:0]        cls_q;
  logic [ADDR_W-1:0] std_ofs_q;
  logic [MID_W-1:0]  std_mid_q, cst_mid_q;
  logic [2:0]        std_opc_q, cst_opc_q;
  logic [2:0]        std_inf_q, cst_inf_q;

  logic kind_ok, clr_hit, held, take;

  assign kind_ok = (err_kind == K_STD) || (err_kind == K_CUST);
  assign clr_hit = reg_we && (reg_addr == 3'd0) && reg_wdata[CLR_BIT];
  assign held    = |cls_q;
  assign take    = err_valid && kind_ok && (!held || clr_hit);
  assign err_flag = held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls_q     <= '0;
      std_ofs_q <= '0;
      std_mid_q <= '0;
      std_opc_q <= '0;
      std_inf_q <= '0;
      cst_mid_q <= '0;
      cst_opc_q <= '0;
      cst_inf_q <= '0;
    end else if (take) begin
      cls_q <= err_kind;
      if (err_kind == K_STD) begin
        std_ofs_q <= err_addr;
        std_mid_q <= err_mid;
        std_opc_q <= err_opc;
        std_inf_q <= {err_dbg, err_sup, err_fetch};
      end else begin
        cst_mid_q <= err_mid;
        cst_opc_q <= err_opc;
        cst_inf_q <= {err_dbg, err_sup, err_fetch};
      end
    end else if (clr_hit) begin
      cls_q <= '0;
    end
  end

  function automatic logic [DW-1:0] mid_word(input logic [MID_W-1:0] m);
    return DW'(m) << MID_LSB;
  endfunction

  function automatic logic [DW-1:0] inf_word(input logic [2:0] i);
    return {28'd0, i[2], 1'b0, i[1], i[0]};
  endfunction

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {30'd0, cls_q};
      3'd1:    reg_rdata = DW'(std_ofs_q);
      3'd2:    reg_rdata = mid_word(std_mid_q);
      3'd3:    reg_rdata = {29'd0, std_opc_q};
      3'd4:    reg_rdata = inf_word(std_inf_q);
      3'd5:    reg_rdata = mid_word(cst_mid_q);
      3'd6:    reg_rdata = {29'd0, cst_opc_q};
      default: reg_rdata = inf_word(cst_inf_q);
    endcase
  end
endmodule

// File: rtl/tgt_errlog_chk.sv
module tgt_errlog_chk #(
  parameter int ADDR_W  = 32,
  parameter int MID_W   = 6,
  parameter int CLR_BIT = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              err_valid,
  input logic [1:0]        err_kind,
  input logic              reg_we,
  input logic [2:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              err_flag,
  input logic [ADDR_W-1:0] std_ofs_q,
  input logic [MID_W-1:0]  cst_mid_q
);
  logic clr, ev;
  assign clr = reg_we && reg_addr == 3'd0 && reg_wdata[CLR_BIT];
  assign ev  = err_valid && (err_kind == 2'b01 || err_kind == 2'b10);

  a_r2_std_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && err_kind == 2'b01 && !err_flag) |=> err_flag);
  a_r3_cust_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && err_kind == 2'b10 && !err_flag) |=> err_flag);
  a_r4_bad_kind_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_flag && !ev) |=> !err_flag);
  a_r8_first_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !clr) |=> (err_flag && $stable(std_ofs_q) && $stable(cst_mid_q)));
  a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !ev) |=> !err_flag);
  a_r10_new_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && ev) |=> err_flag);
endmodule

bind tgt_errlog tgt_errlog_chk #(.ADDR_W(ADDR_W), .MID_W(MID_W), .CLR_BIT(CLR_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_kind(err_kind),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .err_flag(err_flag), .std_ofs_q(std_ofs_q), .cst_mid_q(cst_mid_q)
);

// File: tb/tb_tgt_errlog.sv
`timescale 1ns/1ps
module tb_tgt_errlog;
  logic clk = 0, rst_n = 0;
  logic err_valid = 0, err_fetch = 0, err_sup = 0, err_dbg = 0;
  logic [1:0]  err_kind = 0;
  logic [5:0]  err_mid = 0;
  logic [2:0]  err_opc = 0;
  logic [31:0] err_addr = 0;
  logic        reg_we = 0;
  logic [2:0]  wr_addr = 0, mon_addr = 0, reg_addr;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        err_flag;
  int total = 0, bad = 0;
  bit busy = 0, done = 0;

  always #2.5 clk = ~clk;
  assign reg_addr = reg_we ? wr_addr : mon_addr;

  tgt_errlog dut (
    .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_kind(err_kind),
    .err_mid(err_mid), .err_opc(err_opc), .err_fetch(err_fetch), .err_sup(err_sup),
    .err_dbg(err_dbg), .err_addr(err_addr), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .err_flag(err_flag)
  );

  typedef struct {
    bit          is_flag;
    logic [2:0]  a;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  task automatic expect_rd(input logic [2:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.is_flag = 0; it.a = a; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic expect_flag(input logic e, input string tag);
    item_t it;
    it.is_flag = 1; it.a = 0; it.exp = {31'd0, e}; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic drain();
    do @(posedge clk); while (q.size() != 0 || busy);
  endtask

  task automatic set_ev(input logic [1:0] k, input logic [5:0] m, input logic [2:0] o,
                        input logic f, input logic s, input logic d, input logic [31:0] ad);
    err_valid = 1; err_kind = k; err_mid = m; err_opc = o;
    err_fetch = f; err_sup = s; err_dbg = d; err_addr = ad;
  endtask

  task automatic inject(input logic [1:0] k, input logic [5:0] m, input logic [2:0] o,
                        input logic f, input logic s, input logic d, input logic [31:0] ad);
    @(negedge clk); set_ev(k, m, o, f, s, d, ad);
    @(negedge clk); err_valid = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; wr_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  initial begin : monitor
    item_t it;
    logic [31:0] act;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        busy = 1;
        it = q.pop_front();
        mon_addr = it.a;
        #1;
        act = it.is_flag ? {31'd0, err_flag} : reg_rdata;
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, it.a, act, it.exp);
        end
        busy = 0;
      end
    end
  end

  initial begin : watchdog
    #(5 * 20000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1;
    expect_flag(0, "R1 flag");
    for (int i = 0; i < 8; i++) expect_rd(3'(i), 32'h0, "R1 reset word");
    drain();

    inject(2'b01, 6'h2A, 3'd5, 1, 0, 1, 32'h1234_5678);
    expect_flag(1, "R2 flag");
    expect_rd(0, 32'h1, "R2 main kind");
    expect_rd(1, 32'h1234_5678, "R2 address");
    expect_rd(2, 32'h2A00, "R5 std master id");
    expect_rd(3, 32'h5, "R6 std opcode");
    expect_rd(4, 32'h9, "R7 std info");
    expect_rd(5, 32'h0, "R3 custom untouched");
    drain();

    inject(2'b10, 6'h11, 3'd3, 0, 1, 0, 32'hDEAD_0000);
    inject(2'b01, 6'h01, 3'd1, 0, 0, 0, 32'h0000_0004);
    expect_rd(0, 32'h1, "R8 main held");
    expect_rd(1, 32'h1234_5678, "R8 address held");
    expect_rd(2, 32'h2A00, "R8 mid held");
    expect_rd(5, 32'h0, "R8 custom held");
    drain();

    wr(0, 32'h0000_00FF);
    wr(3, 32'h0000_0100);
    expect_flag(1, "R9 non-clear writes");
    expect_rd(0, 32'h1, "R9 main after non-clear");
    expect_rd(3, 32'h5, "R9 opcode after write");
    drain();

    wr(0, 32'h0000_0100);
    expect_flag(0, "R9 flag cleared");
    expect_rd(0, 32'h0, "R11 main cleared");
    expect_rd(1, 32'h1234_5678, "R9 data kept");
    drain();

    inject(2'b00, 6'h05, 3'd2, 1, 1, 1, 32'hAAAA_AAAA);
    inject(2'b11, 6'h06, 3'd4, 1, 1, 1, 32'hBBBB_BBBB);
    expect_flag(0, "R4 flag");
    expect_rd(0, 32'h0, "R4 main");
    expect_rd(1, 32'h1234_5678, "R4 address");
    expect_rd(5, 32'h0, "R4 custom");
    drain();

    inject(2'b10, 6'h3F, 3'd2, 0, 1, 0, 32'h5555_0000);
    expect_flag(1, "R3 flag");
    expect_rd(0, 32'h2, "R3 main kind");
    expect_rd(5, 32'h3F00, "R5 custom master id");
    expect_rd(6, 32'h2, "R6 custom opcode");
    expect_rd(7, 32'h2, "R7 custom info");
    expect_rd(1, 32'h1234_5678, "R3 std address kept");
    expect_rd(4, 32'h9, "R3 std info kept");
    drain();

    @(negedge clk);
    set_ev(2'b01, 6'h01, 3'd7, 1, 1, 1, 32'hFFFF_FFF0);
    reg_we = 1; wr_addr = 0; reg_wdata = 32'h0000_0101;
    @(negedge clk);
    err_valid = 0; reg_we = 0;
    expect_flag(1, "R10 flag");
    expect_rd(0, 32'h1, "R10 main kind");
    expect_rd(1, 32'hFFFF_FFF0, "R10 address");
    expect_rd(2, 32'h0100, "R10 master id");
    expect_rd(3, 32'h7, "R10 opcode");
    expect_rd(4, 32'hB, "R10 info");
    drain();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule